// File: doc/BRIEF.md
# 128-bit Whole-Register Byte Shifter

This block moves a 128-bit register left or right by a whole number of bytes and fills the vacated bytes with zeros. The register arrives as two 64-bit halves, and the result leaves the same way. Bytes that cross between the halves are carried by a 64-bit byte rotate and then placed by a byte merge. The shift count is an 8-bit immediate. The block uses half-width steps instead of one 128-bit barrel shifter.

The operation is chosen by a 3-bit sub-operation field. A byte shift is requested when the low two bits of the field are both ones. Bit 2 of the field then gives the direction. Any other pattern in the low two bits leaves the register as it came in.

The count falls into one of four regimes:

- A count of zero changes nothing.
- Counts of 1 to 7 need the rotate, merge and shift path.
- Counts of 8 to 15 move one half into the other with a residual shift.
- Counts of 16 or more clear the register.

The result is registered. A valid strobe accompanies it one cycle after the input strobe.

Top module: `bsh_byte_shifter`

## Requirements
- R1: A byte-shift request with a count of 0 returns both halves unchanged.
- R2: A left request with count n in 1..7 gives a new high half equal to the old high half shifted left by 8n bits. The bits vacated at the bottom of that half take the top n bytes of the old low half. The new low half is the old low half shifted left by 8n bits.
- R3: A right request with count n in 1..7 gives a new low half equal to the old low half shifted right by 8n bits. The bits vacated at the top of that half take the bottom n bytes of the old high half. The new high half is the old high half shifted right by 8n bits.
- R4: For count n in 8..15, a left request sets the high half to the old low half shifted left by (n mod 8)*8 bits, and clears the low half. A right request sets the low half to the old high half shifted right by (n mod 8)*8 bits, and clears the high half.
- R5: Any count from 16 to 255 clears both halves, whatever the direction.
- R6: The sub-op field `sub_op` is decoded as follows. The value sub_op[1:0]=2'b11 requests a byte shift. In that case sub_op[2]=1 selects left and sub_op[2]=0 selects right. Any other value of sub_op[1:0] returns both halves unchanged.
- R7: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was sampled high. The result of that input appears on `res_hi`/`res_lo` in the same cycle.
- R8: When `in_valid` is sampled low, `res_hi` and `res_lo` keep their previous values.
- R9: While `rst_n` is low, `out_valid`, `res_hi` and `res_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; operands are sampled when high |
| sub_op | input | 3 | Sub-operation field: [1:0]=11 byte shift, [2] direction (1 left, 0 right) |
| byte_cnt | input | 8 | Shift count in bytes |
| src_hi | input | 64 | Bits 127:64 of the source register |
| src_lo | input | 64 | Bits 63:0 of the source register |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_hi | output | 64 | Bits 127:64 of the result |
| res_lo | output | 64 | Bits 63:0 of the result |

## Verification
Every result is due one clock edge after the edge that samples `in_valid`. The bench drives each request on a falling edge and drops the strobe on the next falling edge. At that same falling edge it reads `out_valid` and both halves, which is half a cycle after the result register loads. Hold behaviour is checked one further falling edge later, when `out_valid` must be low and the halves unchanged. The full sweep of counts 0 to 255 in both directions is compared against a 128-bit reference shift computed in the bench.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    localparam int BSH_HALF_W = 64;
    localparam int BSH_BYTE_W = 8;
    localparam int BSH_CNT_W  = 8;
    localparam int BSH_OP_W   = 3;

    // Count regime chosen for one request.
    typedef enum logic [1:0] {
        RG_PASS  = 2'd0,   // no byte shift, or count of zero
        RG_NEAR  = 2'd1,   // count below one half width
        RG_FAR   = 2'd2,   // count from one to two half widths
        RG_CLEAR = 2'd3    // count of a full register or more
    } regime_e;

    // Low two bits of the sub-op both set request a whole-byte shift.
    function automatic logic op_is_byte_shift(input logic [BSH_OP_W-1:0] op);
        return (op[1:0] == 2'b11);
    endfunction

    // Bit 2 of the sub-op selects the direction: 1 left, 0 right.
    function automatic logic op_is_left(input logic [BSH_OP_W-1:0] op);
        return op[2];
    endfunction

endpackage

// File: rtl/bsh_rot_bytes.sv
// Rotates one half by a whole number of bytes.
module bsh_rot_bytes #(
    parameter int W    = 64,
    parameter int BW   = 8,
    parameter bit LEFT = 1'b1,
    parameter int SHW  = $clog2(W / BW)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    localparam int NB = W / BW;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        always_comb begin
            dout[i*BW +: BW] = '0;
            for (int k = 0; k < NB; k++) begin
                if (int'(amt) == k) begin
                    if (LEFT) begin
                        dout[i*BW +: BW] = din[((i - k + NB) % NB)*BW +: BW];
                    end else begin
                        dout[i*BW +: BW] = din[((i + k) % NB)*BW +: BW];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bsh_shift_bytes.sv
// Shifts one half by a whole number of bytes with zero fill.
module bsh_shift_bytes #(
    parameter int W    = 64,
    parameter int BW   = 8,
    parameter bit LEFT = 1'b1,
    parameter int SHW  = $clog2(W / BW)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    localparam int NB = W / BW;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        always_comb begin
            dout[i*BW +: BW] = '0;
            for (int k = 0; k < NB; k++) begin
                if (int'(amt) == k) begin
                    if (LEFT) begin
                        if (i - k >= 0) begin
                            dout[i*BW +: BW] = din[(i - k)*BW +: BW];
                        end
                    end else begin
                        if (i + k < NB) begin
                            dout[i*BW +: BW] = din[(i + k)*BW +: BW];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bsh_merge_bytes.sv
// Byte merge: the first amt bytes on the chosen side come from the rotated
// word, the rest from the shifted word.
module bsh_merge_bytes #(
    parameter int W        = 64,
    parameter int BW       = 8,
    parameter bit LOW_SIDE = 1'b1,
    parameter int SHW      = $clog2(W / BW)
) (
    input  logic [W-1:0]   rot_in,
    input  logic [W-1:0]   sh_in,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    localparam int NB = W / BW;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic take_rot;
        always_comb begin
            if (LOW_SIDE) begin
                take_rot = (i < int'(amt));
            end else begin
                take_rot = (i >= NB - int'(amt));
            end
            dout[i*BW +: BW] = take_rot ? rot_in[i*BW +: BW] : sh_in[i*BW +: BW];
        end
    end
endmodule

// File: rtl/bsh_byte_shifter.sv
module bsh_byte_shifter #(
    parameter int HALF_W = bsh_pkg::BSH_HALF_W,
    parameter int BYTE_W = bsh_pkg::BSH_BYTE_W,
    parameter int CNT_W  = bsh_pkg::BSH_CNT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [bsh_pkg::BSH_OP_W-1:0]  sub_op,
    input  logic [CNT_W-1:0]              byte_cnt,
    input  logic [HALF_W-1:0]             src_hi,
    input  logic [HALF_W-1:0]             src_lo,
    output logic                          out_valid,
    output logic [HALF_W-1:0]             res_hi,
    output logic [HALF_W-1:0]             res_lo
);
    import bsh_pkg::*;

    localparam int HALF_BYTES = HALF_W / BYTE_W;
    localparam int SHW        = $clog2(HALF_BYTES);

    typedef struct packed {
        logic              vld;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } state_t;

    state_t state_d, state_q;

    logic [SHW-1:0]    sub_amt;
    logic [HALF_W-1:0] rot_lo_l, rot_hi_r;
    logic [HALF_W-1:0] sh_hi_l, sh_lo_l, sh_hi_r, sh_lo_r;
    logic [HALF_W-1:0] mrg_hi_l, mrg_lo_r;
    logic              go_left;
    regime_e           regime;

    // Residual byte amount within one half.
    assign sub_amt = byte_cnt[SHW-1:0];

    // Left path: low half wraps its top bytes into the bottom of the high half.
    bsh_rot_bytes #(.W(HALF_W), .BW(BYTE_W), .LEFT(1'b1), .SHW(SHW)) u_rot_l (
        .din(src_lo), .amt(sub_amt), .dout(rot_lo_l)
    );
    bsh_shift_bytes #(.W(HALF_W), .BW(BYTE_W), .LEFT(1'b1), .SHW(SHW)) u_shl_hi (
        .din(src_hi), .amt(sub_amt), .dout(sh_hi_l)
    );
    bsh_shift_bytes #(.W(HALF_W), .BW(BYTE_W), .LEFT(1'b1), .SHW(SHW)) u_shl_lo (
        .din(src_lo), .amt(sub_amt), .dout(sh_lo_l)
    );
    bsh_merge_bytes #(.W(HALF_W), .BW(BYTE_W), .LOW_SIDE(1'b1), .SHW(SHW)) u_mrg_l (
        .rot_in(rot_lo_l), .sh_in(sh_hi_l), .amt(sub_amt), .dout(mrg_hi_l)
    );

    // Right path: high half wraps its bottom bytes into the top of the low half.
    bsh_rot_bytes #(.W(HALF_W), .BW(BYTE_W), .LEFT(1'b0), .SHW(SHW)) u_rot_r (
        .din(src_hi), .amt(sub_amt), .dout(rot_hi_r)
    );
    bsh_shift_bytes #(.W(HALF_W), .BW(BYTE_W), .LEFT(1'b0), .SHW(SHW)) u_shr_hi (
        .din(src_hi), .amt(sub_amt), .dout(sh_hi_r)
    );
    bsh_shift_bytes #(.W(HALF_W), .BW(BYTE_W), .LEFT(1'b0), .SHW(SHW)) u_shr_lo (
        .din(src_lo), .amt(sub_amt), .dout(sh_lo_r)
    );
    bsh_merge_bytes #(.W(HALF_W), .BW(BYTE_W), .LOW_SIDE(1'b0), .SHW(SHW)) u_mrg_r (
        .rot_in(rot_hi_r), .sh_in(sh_lo_r), .amt(sub_amt), .dout(mrg_lo_r)
    );

    // Regime decode.
    always_comb begin
        go_left = op_is_left(sub_op);
        if (!op_is_byte_shift(sub_op) || (byte_cnt == '0)) begin
            regime = RG_PASS;
        end else if (int'(byte_cnt) < HALF_BYTES) begin
            regime = RG_NEAR;
        end else if (int'(byte_cnt) < 2 * HALF_BYTES) begin
            regime = RG_FAR;
        end else begin
            regime = RG_CLEAR;
        end
    end

    // Next state.
    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            unique case (regime)
                RG_PASS: begin
                    state_d.hi = src_hi;
                    state_d.lo = src_lo;
                end
                RG_NEAR: begin
                    if (go_left) begin
                        state_d.hi = mrg_hi_l;
                        state_d.lo = sh_lo_l;
                    end else begin
                        state_d.hi = sh_hi_r;
                        state_d.lo = mrg_lo_r;
                    end
                end
                RG_FAR: begin
                    if (go_left) begin
                        state_d.hi = sh_lo_l;
                        state_d.lo = '0;
                    end else begin
                        state_d.hi = '0;
                        state_d.lo = sh_hi_r;
                    end
                end
                default: begin
                    state_d.hi = '0;
                    state_d.lo = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign res_hi    = state_q.hi;
    assign res_lo    = state_q.lo;

endmodule

// File: rtl/bsh_byte_shifter_chk.sv
module bsh_byte_shifter_chk #(
    parameter int HALF_W = 64,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        sub_op,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic [HALF_W-1:0] src_hi,
    input logic [HALF_W-1:0] src_lo,
    input logic              out_valid,
    input logic [HALF_W-1:0] res_hi,
    input logic [HALF_W-1:0] res_lo
);
    localparam int HB = HALF_W / 8;

    // R7
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_hi) && $stable(res_lo)));

    // R1
    a_r1_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_op[1:0] == 2'b11 && byte_cnt == '0)
        |=> (res_hi == $past(src_hi) && res_lo == $past(src_lo)));

    // R6
    a_r6_not_byte_op: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_op[1:0] != 2'b11)
        |=> (res_hi == $past(src_hi) && res_lo == $past(src_lo)));

    // R5
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_op[1:0] == 2'b11 && int'(byte_cnt) >= 2 * HB)
        |=> (res_hi == '0 && res_lo == '0));

    // R4
    a_r4_far_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_op == 3'b111 && int'(byte_cnt) >= HB && int'(byte_cnt) < 2 * HB)
        |=> (res_lo == '0));
    a_r4_far_right_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_op == 3'b011 && int'(byte_cnt) >= HB && int'(byte_cnt) < 2 * HB)
        |=> (res_hi == '0));

    // R9
    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && res_hi == '0 && res_lo == '0));

endmodule

bind bsh_byte_shifter bsh_byte_shifter_chk #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
    .byte_cnt(byte_cnt), .src_hi(src_hi), .src_lo(src_lo),
    .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/bsh_byte_shifter_tb.sv
`timescale 1ns/1ps
module bsh_byte_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  sub_op = '0;
    logic [7:0]  byte_cnt = '0;
    logic [63:0] src_hi = '0;
    logic [63:0] src_lo = '0;
    logic        out_valid;
    logic [63:0] res_hi, res_lo;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bsh_byte_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
        .byte_cnt(byte_cnt), .src_hi(src_hi), .src_lo(src_lo),
        .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo)
    );

    localparam logic [2:0] OP_L = 3'b111;   // R6: byte shift, left
    localparam logic [2:0] OP_R = 3'b011;   // R6: byte shift, right

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  cnt;
        logic [63:0] ehi;
        logic [63:0] elo;
    } vec_t;

    localparam logic [63:0] P_HI = 64'h0011223344556677;
    localparam logic [63:0] P_LO = 64'h8899AABBCCDDEEFF;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{OP_L,   8'd3,   64'h33445566778899AA, 64'hBBCCDDEEFF000000}, // R2
        '{OP_L,   8'd0,   P_HI,                 P_LO},                 // R1
        '{OP_R,   8'd5,   64'h0000000000001122, 64'h33445566778899AA}, // R3
        '{OP_R,   8'd1,   64'h0000112233445566, 64'h778899AABBCCDDEE}, // R3
        '{OP_R,   8'd7,   64'h0000000000000000, 64'h1122334455667788}, // R3
        '{OP_L,   8'd8,   64'h8899AABBCCDDEEFF, 64'h0},                // R4
        '{OP_L,   8'd10,  64'hAABBCCDDEEFF0000, 64'h0},                // R4
        '{OP_L,   8'd15,  64'hFF00000000000000, 64'h0},                // R4
        '{OP_R,   8'd12,  64'h0,                64'h0000000000112233}, // R4
        '{OP_L,   8'd16,  64'h0,                64'h0},                // R5
        '{OP_R,   8'd200, 64'h0,                64'h0},                // R5
        '{3'b110, 8'd4,   P_HI,                 P_LO}                  // R6
    };

    task automatic check(input string req, input logic [63:0] ahi, input logic [63:0] alo,
                         input logic [63:0] ehi, input logic [63:0] elo);
        n_cmp++;
        if (ahi !== ehi || alo !== elo) begin
            n_bad++;
            $display("FAIL %s: actual %h_%h expected %h_%h", req, ahi, alo, ehi, elo);
        end
    endtask

    task automatic check_bit(input string req, input logic a, input logic e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, a, e);
        end
    endtask

    // Drive one request on a falling edge; the result is read one cycle later.
    task automatic run(input logic [2:0] op, input logic [7:0] cnt,
                       input logic [63:0] hi, input logic [63:0] lo);
        @(negedge clk);
        in_valid = 1'b1; sub_op = op; byte_cnt = cnt; src_hi = hi; src_lo = lo;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] ref_shift(input logic left, input int n,
                                               input logic [127:0] v);
        if (n >= 16) return '0;
        return left ? (v << (8 * n)) : (v >> (8 * n));
    endfunction

    initial begin
        #(4 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] r;
        logic [63:0]  keep_hi, keep_lo;

        // R9: reset state
        repeat (3) @(negedge clk);
        check_bit("R9 valid", out_valid, 1'b0);
        check("R9 data", res_hi, res_lo, 64'h0, 64'h0);
        rst_n = 1'b1;

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            run(VECS[i].op, VECS[i].cnt, P_HI, P_LO);
            check_bit("R7 valid", out_valid, 1'b1);
            check($sformatf("R2 R3 R4 R5 R6 R1 vector %0d", i), res_hi, res_lo,
                  VECS[i].ehi, VECS[i].elo);
        end

        // R8: hold with no strobe, then strobe drop
        keep_hi = res_hi; keep_lo = res_lo;
        @(negedge clk);
        sub_op = OP_L; byte_cnt = 8'd2; src_hi = '1; src_lo = '1;
        @(negedge clk);
        check_bit("R7 valid low", out_valid, 1'b0);
        check("R8 hold", res_hi, res_lo, keep_hi, keep_lo);

        // R6: other non-byte sub-op patterns pass through
        for (int p = 0; p < 8; p++) begin
            if (p[1:0] != 2'b11) begin
                run(3'(p), 8'd9, 64'hDEADBEEF01234567, 64'h76543210FEEDC0DE);
                check("R6 passthrough", res_hi, res_lo,
                      64'hDEADBEEF01234567, 64'h76543210FEEDC0DE);
            end
        end

        // Full sweep: every count, both directions (R1 R2 R3 R4 R5)
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < 256; n++) begin
                logic [127:0] v;
                v = {64'h0123456789ABCDEF ^ {8{8'(n)}}, 64'hF0E1D2C3B4A59687 + 64'(n)};
                r = ref_shift(d == 1, n, v);
                run(d == 1 ? OP_L : OP_R, 8'(n), v[127:64], v[63:0]);
                check($sformatf("R2 R3 R4 R5 sweep dir=%0d n=%0d", d, n),
                      res_hi, res_lo, r[127:64], r[63:0]);
            end
        end

        // R9: reset mid-run clears
        run(OP_L, 8'd1, P_HI, P_LO);
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("R9 valid after reset", out_valid, 1'b0);
        check("R9 data after reset", res_hi, res_lo, 64'h0, 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule